// File: doc/BRIEF.md
# Smoothed Segment Utilization Bar Graph

This block measures how busy a shared 100 Mb/s medium is and drives a ten-segment bar graph that glides between levels instead of flickering. Each bit time is marked by a clock enable. A companion flag says whether the medium carried a signal during that bit. Every bit with activity counts as busy, including preambles, runt frames and collision fragments. A millisecond tick, whose length in bit times is a parameter, paces two slower events.

At each sample point the busy-bit count is turned into a utilization result in 10% steps, and the count restarts. The displayed value, called the report, only moves at step points. At each step point it moves by one 10% level toward the result. A burst of traffic therefore shows up as a bar that climbs one segment per step. The ten bar outputs are active low, so a driven 0 lights a segment.

Top module: `util_bar_graph`

## Requirements
- R1: During reset and right after it, the result and the report are both 0% and all ten bar outputs are 1.
- R2: A bit time adds one to the busy count only when the bit enable and the busy flag are both high in the same cycle. A busy flag raised in a cycle without the bit enable is not counted.
- R3: Once every SAMPLE_MS millisecond ticks the count is sampled and then cleared. The new result is floor(10 × count / window) levels, where the window is BITS_PER_MS × SAMPLE_MS bit times. For example, 35% busy gives level 3.
- R4: The result saturates at level 10 (100%). A medium busy on every bit shows all ten segments lit.
- R5: The report changes only in the cycle after a step point. A step point occurs once every STEP_MS millisecond ticks.
- R6: At a step point a report below the result rises by exactly one level, and it never passes the result.
- R7: At a step point a report above the result falls by exactly one level, and it stops when it equals the result.
- R8: Bar output k (k = 0..9) is 0 when the report is at least k+1 levels, and 1 otherwise. The lit segments always form a run that starts at bar 0.
- R9: A sample taken between step points updates only the target, and the report does not move until the next step point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | High for one cycle per bit time |
| busy | input | 1 | Medium active during this bit time |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bar_n | output | 10 | Bar segments, active low, bit 0 is the lowest segment |

## Verification
Busy patterns with a fixed duty cycle are held long enough for the bar to settle. Duties of 0, 10, 30, 50 and 100% test exact levels. Duties of 35% and 95% test truncation rather than rounding. Going up and then down through the table shows that rising and falling are both limited to one segment per step and stop at the target. A pattern that raises busy only in cycles without a bit enable must read 0%. A full-busy pattern at half the bit rate must read 100%, which shows that the window is measured in bit times, not cycles. A continuous monitor checks that every bar change is a single level, forms a valid run, and is spaced at least one step period from the previous change.

// File: rtl/util_bar_pkg.sv
package util_bar_pkg;
    localparam int NUM_LEVELS = 10;
    localparam int LVL_W      = 4;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        level_t result;
        level_t report;
    } disp_state_t;
endpackage

// File: rtl/util_tick_div.sv
module util_tick_div #(
    parameter int DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_out
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t div_d, div_q;

    always_comb begin
        div_d    = div_q;
        tick_out = tick_in && (div_q.cnt == CW'(DIV - 1));
        if (tick_in) begin
            div_d.cnt = tick_out ? '0 : div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/util_busy_count.sv
module util_busy_count #(
    parameter int WIN   = 4000000,
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             busy,
    input  logic             sample,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;
    logic       hit;

    always_comb begin
        cnt_d = cnt_q;
        hit   = bit_en && busy;
        count = cnt_q.cnt;
        if (sample) begin
            // the bit in the sample cycle opens the next window
            cnt_d.cnt = hit ? CNT_W'(1) : '0;
        end else if (hit && (cnt_q.cnt != CNT_W'(WIN))) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/util_level_quant.sv
module util_level_quant
    import util_bar_pkg::*;
#(
    parameter int WIN   = 4000000,
    parameter int CNT_W = 22
) (
    input  logic [CNT_W-1:0] count,
    output level_t           level
);
    localparam int PW = CNT_W + LVL_W;

    logic [PW-1:0]         scaled;
    logic [NUM_LEVELS-1:0] reached;

    assign scaled = PW'(count) * PW'(NUM_LEVELS);

    for (genvar k = 1; k <= NUM_LEVELS; k++) begin : g_thr
        localparam longint THR = longint'(k) * longint'(WIN);
        assign reached[k-1] = (scaled >= PW'(THR));
    end

    always_comb level = level_t'($countones(reached));
endmodule

// File: rtl/util_bar_graph.sv
module util_bar_graph
    import util_bar_pkg::*;
#(
    parameter int BITS_PER_MS = 100000,
    parameter int SAMPLE_MS   = 40,
    parameter int STEP_MS     = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  busy,
    input  logic                  ms_tick,
    output logic [NUM_LEVELS-1:0] bar_n
);
    localparam int WIN   = BITS_PER_MS * SAMPLE_MS;
    localparam int CNT_W = $clog2(WIN + 1);

    logic             sample_fire;
    logic             step_fire;
    logic [CNT_W-1:0] win_count;
    level_t           win_level;
    level_t           target;
    level_t           result_q;
    level_t           report_q;
    disp_state_t      disp_d, disp_q;

    util_tick_div #(.DIV(SAMPLE_MS)) u_sample_div (
        .clk(clk), .rst_n(rst_n), .tick_in(ms_tick), .tick_out(sample_fire)
    );

    util_tick_div #(.DIV(STEP_MS)) u_step_div (
        .clk(clk), .rst_n(rst_n), .tick_in(ms_tick), .tick_out(step_fire)
    );

    util_busy_count #(.WIN(WIN), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .busy(busy),
        .sample(sample_fire), .count(win_count)
    );

    util_level_quant #(.WIN(WIN), .CNT_W(CNT_W)) u_quant (
        .count(win_count), .level(win_level)
    );

    always_comb begin
        disp_d = disp_q;
        target = sample_fire ? win_level : disp_q.result;
        disp_d.result = target;
        if (step_fire) begin
            if (disp_q.report < target)      disp_d.report = disp_q.report + 1'b1;
            else if (disp_q.report > target) disp_d.report = disp_q.report - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) disp_q <= '0;
        else        disp_q <= disp_d;
    end

    assign result_q = disp_q.result;
    assign report_q = disp_q.report;

    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_bar
        assign bar_n[k] = !(report_q >= level_t'(k + 1));
    end
endmodule

// File: rtl/util_bar_graph_chk.sv
module util_bar_graph_chk
    import util_bar_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step_fire,
    input level_t                target,
    input level_t                result_q,
    input level_t                report_q,
    input logic [NUM_LEVELS-1:0] bar_n
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (report_q == '0 && result_q == '0 && (&bar_n)));

    assert_result_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_q <= level_t'(NUM_LEVELS) && report_q <= level_t'(NUM_LEVELS));

    assert_hold_between_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_fire |=> $stable(report_q));

    assert_rise_no_overshoot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (report_q > $past(report_q)) |->
            (report_q == $past(report_q) + 1'b1 && report_q <= $past(target)));

    assert_fall_no_undershoot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (report_q < $past(report_q)) |->
            (report_q == $past(report_q) - 1'b1 && report_q >= $past(target)));

    assert_bar_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bar_n) == int'(report_q));

    assert_bar_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~bar_n) & ((~bar_n) + 1'b1)) == '0);
endmodule

bind util_bar_graph util_bar_graph_chk u_chk (
    .clk(clk), .rst_n(rst_n), .step_fire(step_fire), .target(target),
    .result_q(result_q), .report_q(report_q), .bar_n(bar_n)
);

// File: tb/sim_util_bar_graph.sv
`timescale 1ns/1ps
module sim_util_bar_graph;
    localparam int BPM   = 10;
    localparam int SMS   = 4;
    localparam int STMS  = 10;
    localparam int STEPC = BPM * STMS;   // cycles per step at full bit rate
    localparam int NV    = 9;
    // {busy bits per period, period, expected level}
    localparam int VEC [NV][3] = '{
        '{0, 10, 0}, '{3, 10, 3}, '{7, 20, 3}, '{10, 10, 10},
        '{19, 20, 9}, '{5, 10, 5}, '{1, 10, 1}, '{0, 10, 0}, '{2, 10, 2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       busy = 1'b0;
    logic       ms_tick = 1'b0;
    logic [9:0] bar_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int on_cnt = 0;
    int per = 10;
    bit half = 1'b0;
    bit gate = 1'b0;
    bit tgl = 1'b0;
    int ph = 0;
    int bc = 0;
    logic [9:0] last_bar = '1;
    int last_t = 0;
    bit done = 1'b0;

    util_bar_graph #(.BITS_PER_MS(BPM), .SAMPLE_MS(SMS), .STEP_MS(STMS)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .busy(busy),
        .ms_tick(ms_tick), .bar_n(bar_n)
    );

    always #4 clk = ~clk;

    function automatic logic [9:0] bar_of(int lvl);
        logic [9:0] b;
        for (int k = 0; k < 10; k++) b[k] = !(lvl >= k + 1);
        return b;
    endfunction

    function automatic int lvl_of(logic [9:0] b);
        return 10 - $countones(b);
    endfunction

    // stimulus generator and change monitor, both away from the active edge
    always @(negedge clk) begin
        logic be;
        cyc = cyc + 1;
        if (!rst_n) begin
            last_bar = '1;
            last_t = cyc;
        end else if (bar_n !== last_bar) begin
            checks = checks + 1;
            if (lvl_of(bar_n) - lvl_of(last_bar) != 1 && lvl_of(last_bar) - lvl_of(bar_n) != 1) begin
                failures = failures + 1;
                $display("FAIL R6/R7 bar jump: actual %b expected one level from %b", bar_n, last_bar);
            end
            if (bar_n !== bar_of(lvl_of(bar_n))) begin
                failures = failures + 1;
                $display("FAIL R8 bar shape: actual %b expected %b", bar_n, bar_of(lvl_of(bar_n)));
            end
            if (cyc - last_t < STEPC) begin
                failures = failures + 1;
                $display("FAIL R5/R9 change spacing: actual %0d expected >= %0d", cyc - last_t, STEPC);
            end
            last_bar = bar_n;
            last_t = cyc;
        end
        tgl = !tgl;
        be = half ? tgl : 1'b1;
        busy = gate ? !be : (ph < on_cnt);
        ph = (ph + 1 >= per) ? 0 : ph + 1;
        ms_tick = be && (bc == BPM - 1);
        if (be) bc = (bc == BPM - 1) ? 0 : bc + 1;
        bit_en = be;
    end

    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bar(string req, logic [9:0] exp);
        checks = checks + 1;
        if (bar_n !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual %b expected %b", req, bar_n, exp);
        end
    endtask

    initial begin
        wait_cyc(5);
        check_bar("R1 in reset", 10'h3FF);
        rst_n = 1'b1;
        wait_cyc(1);
        check_bar("R1 after release", 10'h3FF);
        wait_cyc(300);
        check_bar("R1 idle stays dark", 10'h3FF);

        // vector walk: R3 truncation, R4 saturation, R6 rise, R7 fall, R8 mapping
        for (int i = 0; i < NV; i++) begin
            on_cnt = VEC[i][0];
            per = VEC[i][1];
            wait_cyc(1300);
            check_bar($sformatf("R3/R4/R6/R7/R8 vec%0d", i), bar_of(VEC[i][2]));
        end

        // R2: busy only in cycles without a bit enable
        half = 1'b1;
        gate = 1'b1;
        wait_cyc(2600);
        check_bar("R2 busy off bit time ignored", 10'h3FF);

        // R2/R4: full busy at half bit rate saturates
        gate = 1'b0;
        on_cnt = 10;
        per = 10;
        wait_cyc(2600);
        check_bar("R4 full busy half rate", 10'h000);

        // R1: reset mid-run clears the display
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        check_bar("R1 mid-run reset", 10'h3FF);
        rst_n = 1'b1;
        wait_cyc(1);
        check_bar("R1 mid-run release", 10'h3FF);
        wait_cyc(STEPC - 10);
        check_bar("R5 no move before first step", 10'h3FF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule